// File: doc/BRIEF.md
# CPU Interrupt, Reset and Bus-Hold Sequencer

This block sits beside a 16-bit CPU core and handles three pieces of control sequencing. It qualifies a raw reset input so that only a sustained request resets the core. It decides at each instruction boundary whether to service a non-maskable or a maskable interrupt, and it runs the two-pulse acknowledge that fetches a vector number from an external interrupt controller. It also hands the bus to a DMA requester: it floats the bus outputs first and then acknowledges.

The core reports each finished instruction with a one-cycle `insn_done` pulse and supplies its current interrupt-enable flag. It receives a reset, the restart address, a clear-enable request and a vector strobe with a number. `bus_idle` marks the cycles in which a bus transfer is not in progress, so ownership may change hands there.

Top module: `cpu_seq_ctrl`

## Requirements
- R1: `core_rst` rises after the fourth consecutive rising clock edge that samples `rst_raw` high. It falls at the first edge that samples `rst_raw` low. A high pulse on `rst_raw` lasting three or fewer edges leaves `core_rst` low and leaves all other outputs unchanged.
- R2: `start_addr` always reads 20'hFFFF0. While `core_rst` is high, `if_clear` is high. At the edge where `core_rst` falls, `inta`, `vec_req`, `hlda` and `bus_float` are all low, and any latched non-maskable request has been discarded.
- R3: A maskable request starts only at an edge where `insn_done`, `intr` and `if_flag` are all 1, no non-maskable request is latched, and the bus is not floated. After that edge, `inta` is high for one cycle, low for one cycle and high for one cycle. While `insn_done` is 0, `inta` stays low.
- R4: `vec_in` is captured during the second `inta` cycle. In the next cycle `vec_req` is high for one cycle, `vec_num` equals the captured byte and `if_clear` is high.
- R5: A rising edge on `nmi` is latched until the next instruction boundary, whatever `if_flag` is. In the cycle after that boundary, `vec_req` is high with `vec_num` = 2 and `inta` stays low. An `nmi` level held high across later boundaries causes no second service.
- R6: When a non-maskable request is latched and a maskable request qualifies at the same boundary, only the non-maskable one is serviced (vector 2, no `inta`).
- R7: `hold` is honoured only at an edge where `bus_idle` is 1 and no acknowledge sequence is running, including one starting at that edge. `bus_float` rises at that edge and `hlda` rises one edge later.
- R8: While `hlda` is high, the first edge that samples `hold` low clears `hlda` and `bus_float` together. No interrupt sequence starts while `bus_float` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_raw | input | 1 | Unfiltered reset request, active high |
| intr | input | 1 | Maskable interrupt request, level sensitive |
| nmi | input | 1 | Non-maskable interrupt request, rising-edge sensitive |
| hold | input | 1 | DMA bus request |
| bus_idle | input | 1 | High when no bus transfer is in progress |
| insn_done | input | 1 | One-cycle pulse at each instruction boundary |
| if_flag | input | 1 | Core's interrupt-enable flag |
| vec_in | input | 8 | Vector byte from the interrupt controller |
| core_rst | output | 1 | Qualified core reset |
| start_addr | output | 20 | Restart address after reset |
| if_clear | output | 1 | Request to clear the interrupt-enable flag |
| vec_req | output | 1 | Vector-fetch strobe to the core |
| vec_num | output | 8 | Vector number that goes with `vec_req` |
| inta | output | 1 | Interrupt acknowledge pulse |
| hlda | output | 1 | Hold acknowledge |
| bus_float | output | 1 | Enable for tri-stating address, data and control |

## Verification
The assertions assume that `insn_done` is a clean single-cycle pulse, that `intr` and `if_flag` are steady at the boundary edge, and that `rst_raw` is driven to a known level from time zero so that the reset shift register fills with defined values. The bench drives every input shortly after a rising edge and holds it through the next edge. It raises `nmi` only from a low level, and it releases `intr` once a boundary has passed, so that only intended requests reach an edge. Reset glitch tests run with the bus already handed over, which makes any disturbance from a short pulse visible on `hlda`.

// File: rtl/cpu_seq_ctrl.sv
module cpu_seq_ctrl #(
  parameter int RST_LEN = 4,
  parameter int VW = 8,
  parameter int AW = 20,
  parameter logic [AW-1:0] RESET_ADDR = 20'hFFFF0,
  parameter logic [VW-1:0] NMI_VEC = 8'd2
) (
  input  logic          clk,
  input  logic          rst_raw,
  input  logic          intr,
  input  logic          nmi,
  input  logic          hold,
  input  logic          bus_idle,
  input  logic          insn_done,
  input  logic          if_flag,
  input  logic [VW-1:0] vec_in,
  output logic          core_rst,
  output logic [AW-1:0] start_addr,
  output logic          if_clear,
  output logic          vec_req,
  output logic [VW-1:0] vec_num,
  output logic          inta,
  output logic          hlda,
  output logic          bus_float
);

  typedef enum logic [2:0] {I_IDLE, I_ACK1, I_GAP, I_ACK2, I_VEC} int_st_t;
  typedef enum logic [1:0] {H_RUN, H_FLOAT, H_ACK} hold_st_t;

  logic [RST_LEN-1:0] rst_sh;
  int_st_t   ist;
  hold_st_t  hst;
  logic      nmi_q, nmi_pend;
  logic [VW-1:0] vec_reg;
  logic      int_idle, bus_ours, take_nmi, take_intr, grant;

  always_ff @(posedge clk) rst_sh <= {rst_sh[RST_LEN-2:0], rst_raw};

  assign core_rst   = &rst_sh;
  assign start_addr = RESET_ADDR;

  assign int_idle  = (ist == I_IDLE);
  assign bus_ours  = (hst == H_RUN);
  assign take_nmi  = insn_done & nmi_pend & int_idle & bus_ours;
  assign take_intr = insn_done & intr & if_flag & ~nmi_pend & int_idle & bus_ours;
  assign grant     = hold & bus_idle & int_idle & bus_ours & ~take_nmi & ~take_intr;

  always_ff @(posedge clk) begin
    if (core_rst) begin
      ist      <= I_IDLE;
      nmi_q    <= nmi;
      nmi_pend <= 1'b0;
      vec_reg  <= '0;
    end else begin
      nmi_q <= nmi;
      if (nmi & ~nmi_q)  nmi_pend <= 1'b1;
      else if (take_nmi) nmi_pend <= 1'b0;
      case (ist)
        I_IDLE: begin
          if (take_nmi) begin
            ist     <= I_VEC;
            vec_reg <= NMI_VEC;
          end else if (take_intr) begin
            ist <= I_ACK1;
          end
        end
        I_ACK1: ist <= I_GAP;
        I_GAP:  ist <= I_ACK2;
        I_ACK2: begin
          ist     <= I_VEC;
          vec_reg <= vec_in;
        end
        I_VEC:  ist <= I_IDLE;
        default: ist <= I_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (core_rst) hst <= H_RUN;
    else begin
      case (hst)
        H_RUN:   if (grant) hst <= H_FLOAT;
        H_FLOAT: hst <= H_ACK;
        H_ACK:   if (!hold) hst <= H_RUN;
        default: hst <= H_RUN;
      endcase
    end
  end

  assign inta      = (ist == I_ACK1) | (ist == I_ACK2);
  assign vec_req   = (ist == I_VEC);
  assign vec_num   = vec_reg;
  assign if_clear  = core_rst | vec_req;
  assign bus_float = (hst != H_RUN);
  assign hlda      = (hst == H_ACK);

  assert_reset_needs_raw_R1: assert property (@(posedge clk)
    $rose(core_rst) |-> $past(rst_raw));

  assert_quiet_after_reset_R2: assert property (@(posedge clk)
    $fell(core_rst) |-> (!inta && !vec_req && !hlda && !bus_float));

  assert_inta_at_boundary_R3: assert property (@(posedge clk) disable iff (core_rst !== 1'b0)
    $rose(inta) && !$past(inta, 2) |-> $past(insn_done) && $past(intr) && $past(if_flag));

  assert_vec_after_ack_R4: assert property (@(posedge clk) disable iff (core_rst !== 1'b0)
    $rose(vec_req) && $past(inta) |-> vec_num == $past(vec_in));

  assert_nmi_vector_R5: assert property (@(posedge clk) disable iff (core_rst !== 1'b0)
    $rose(vec_req) && !$past(inta) |-> vec_num == NMI_VEC);

  assert_hlda_after_float_R7: assert property (@(posedge clk) disable iff (core_rst !== 1'b0)
    $rose(hlda) |-> $past(bus_float));

  assert_release_R8: assert property (@(posedge clk) disable iff (core_rst !== 1'b0)
    hlda && !hold |=> !hlda && !bus_float);

  assert_no_ack_while_floated_R8: assert property (@(posedge clk) disable iff (core_rst !== 1'b0)
    bus_float && $past(bus_float) |-> !$rose(inta));

endmodule

// File: tb/tb_cpu_seq_ctrl.sv
module tb_cpu_seq_ctrl;
  logic clk = 1'b0;
  logic rst_raw, intr, nmi, hold, bus_idle, insn_done, if_flag;
  logic [7:0] vec_in;
  logic core_rst, if_clear, vec_req, inta, hlda, bus_float;
  logic [19:0] start_addr;
  logic [7:0] vec_num;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cpu_seq_ctrl dut (
    .clk(clk), .rst_raw(rst_raw), .intr(intr), .nmi(nmi), .hold(hold),
    .bus_idle(bus_idle), .insn_done(insn_done), .if_flag(if_flag), .vec_in(vec_in),
    .core_rst(core_rst), .start_addr(start_addr), .if_clear(if_clear),
    .vec_req(vec_req), .vec_num(vec_num), .inta(inta), .hlda(hlda), .bus_float(bus_float)
  );

  // row: {nmi, intr, if_flag, kind[1:0], vec_in[7:0], exp_vec[7:0]}; kind 0 none, 1 nmi, 2 maskable
  localparam logic [20:0] ROWS [7] = '{
    {1'b0, 1'b1, 1'b1, 2'd2, 8'h21, 8'h21},
    {1'b0, 1'b1, 1'b0, 2'd0, 8'h33, 8'h00},
    {1'b1, 1'b0, 1'b0, 2'd1, 8'h44, 8'h02},
    {1'b1, 1'b1, 1'b1, 2'd1, 8'h55, 8'h02},
    {1'b0, 1'b0, 1'b1, 2'd0, 8'h66, 8'h00},
    {1'b0, 1'b1, 1'b1, 2'd2, 8'hFF, 8'hFF},
    {1'b1, 1'b1, 1'b0, 2'd1, 8'h77, 8'h02}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic full_reset();
    rst_raw = 1'b1;
    repeat (4) tick();
    chk(core_rst == 1'b1, "R1 reset after four edges", core_rst, 1);
    chk(if_clear == 1'b1, "R2 if_clear during reset", if_clear, 1);
    chk(start_addr == 20'hFFFF0, "R2 start address", start_addr, 20'hFFFF0);
    tick();
    rst_raw = 1'b0;
    tick();
    chk(core_rst == 1'b0, "R1 reset release", core_rst, 0);
    chk({inta, vec_req, hlda, bus_float} == 4'b0, "R2 quiet after reset",
        {inta, vec_req, hlda, bus_float}, 0);
  endtask

  task automatic boundary();
    insn_done = 1'b1;
    tick();
    insn_done = 1'b0;
    intr = 1'b0;
  endtask

  initial begin
    rst_raw = 1'b1; intr = 0; nmi = 0; hold = 0; bus_idle = 0;
    insn_done = 0; if_flag = 0; vec_in = 8'h00;
    #1;
    full_reset();

    foreach (ROWS[i]) begin
      logic [20:0] r;
      r = ROWS[i];
      vec_in = r[15:8];
      if (r[20]) begin
        nmi = 1'b1;
        tick();
        nmi = 1'b0;
      end
      intr = r[19];
      if_flag = r[18];
      boundary();
      case (r[17:16])
        2'd2: begin
          chk(inta == 1'b1, "R3 first inta", inta, 1);
          tick();
          chk(inta == 1'b0, "R3 inta gap", inta, 0);
          tick();
          chk(inta == 1'b1, "R3 second inta", inta, 1);
          tick();
          chk(vec_req && vec_num == r[7:0] && if_clear, "R4 vector delivered",
              {vec_req, vec_num, if_clear}, {1'b1, r[7:0], 1'b1});
          tick();
          chk(vec_req == 1'b0, "R4 single vector strobe", vec_req, 0);
        end
        2'd1: begin
          chk(vec_req && vec_num == 8'd2 && !inta, "R5/R6 nmi vector 2 without inta",
              {vec_req, vec_num, inta}, {1'b1, 8'd2, 1'b0});
          tick();
          chk(vec_req == 1'b0, "R5 single nmi strobe", vec_req, 0);
        end
        default: begin
          for (int k = 0; k < 4; k++) begin
            chk(!inta && !vec_req, "R3 request not accepted", {inta, vec_req}, 0);
            tick();
          end
        end
      endcase
      tick();
    end

    // R3: no acknowledge without an instruction boundary
    intr = 1'b1; if_flag = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(inta == 1'b0, "R3 no inta without insn_done", inta, 0);
    end
    intr = 1'b0;

    // R5: nmi latched until boundary; held level does not retrigger
    nmi = 1'b1;
    repeat (5) tick();
    chk(vec_req == 1'b0, "R5 nmi waits for boundary", vec_req, 0);
    if_flag = 1'b0;
    boundary();
    chk(vec_req && vec_num == 8'd2, "R5 latched nmi serviced", {vec_req, vec_num}, {1'b1, 8'd2});
    repeat (2) tick();
    boundary();
    chk(vec_req == 1'b0, "R5 held nmi no retrigger", vec_req, 0);
    nmi = 1'b0;
    tick();

    // R7: hold ignored while bus busy, then granted
    hold = 1'b1; bus_idle = 1'b0;
    repeat (3) tick();
    chk(bus_float == 1'b0, "R7 hold waits for bus_idle", bus_float, 0);
    bus_idle = 1'b1;
    tick();
    chk(bus_float && !hlda, "R7 float before hlda", {bus_float, hlda}, 2'b10);
    tick();
    chk(bus_float && hlda, "R7 hlda one edge later", {bus_float, hlda}, 2'b11);

    // R8: no interrupt while floated
    intr = 1'b1; if_flag = 1'b1;
    boundary();
    chk(inta == 1'b0, "R8 no inta while floated", inta, 0);
    tick();
    chk(inta == 1'b0, "R8 still no inta", inta, 0);

    // R1: short reset pulse leaves state alone
    rst_raw = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(core_rst == 1'b0, "R1 short pulse ignored", core_rst, 0);
    end
    rst_raw = 1'b0;
    tick();
    chk(hlda == 1'b1, "R1 short pulse keeps hlda", hlda, 1);

    // R8: release
    hold = 1'b0;
    tick();
    chk(!hlda && !bus_float, "R8 release together", {hlda, bus_float}, 0);

    // R7: hold deferred while acknowledge runs
    vec_in = 8'h9A;
    intr = 1'b1; if_flag = 1'b1; hold = 1'b1;
    boundary();
    chk(inta == 1'b1 && bus_float == 1'b0, "R7 interrupt wins boundary", {inta, bus_float}, 2'b10);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(bus_float == 1'b0, "R7 no float during ack", bus_float, 0);
    end
    tick();
    chk(bus_float == 1'b1, "R7 float after ack ends", bus_float, 1);
    hold = 1'b0;
    repeat (2) tick();

    // R2: reset discards a latched nmi
    nmi = 1'b1;
    tick();
    nmi = 1'b0;
    full_reset();
    boundary();
    chk(vec_req == 1'b0, "R2 pending nmi cleared by reset", vec_req, 0);
    tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule